// File: doc/BRIEF.md
# Strided Vector Load/Store Unit

This block moves one vector between a banked word memory and a vector register. A command carries a base word address, a signed stride counted in words, a transfer length and a direction bit. Element i lives at address base + i*stride. The unit issues at most one element access per clock. For a load, it writes each returned 64-bit word into register slot i. For a store, it reads slot i and writes it to the same strided address.

The memory answers every read a fixed number of cycles after the request, and its pipeline accepts a new request every cycle. A streaming transfer therefore pays the memory latency once per vector, not once per element. The memory has 16 interleaved banks, and a bank stays occupied for a few cycles after it is hit. When the next element falls in a bank that is still occupied, the unit holds issue until that bank frees.

A one-cycle `done` pulse marks completion. A new command is taken only while the unit is idle.

Top module: `vlsu_stride`

## Requirements
- R1: `cmd_ready` is high exactly when the unit is idle. A `cmd_valid` pulse while `cmd_ready` is low is ignored: it causes no memory access and does not change the running transfer's timing.
- R2: Element i is accessed at word address (base + i*stride) mod 2^16. The stride is a two's-complement word count.
- R3: Only elements 0 to len-1 are transferred. A `cmd_len` above 64 is clamped to 64, the register capacity.
- R4: A `cmd_len` of 0 raises `done` in the cycle after acceptance and makes no memory request.
- R5: For a load, the word returned for element i is written to register slot i, 12 cycles after its request.
- R6: Issue is fully pipelined. A load with stride 1 and N elements raises `done` N+12 cycles after acceptance. A store with stride 1 raises `done` N cycles after acceptance.
- R7: The bank is word-address bits [3:0]. A bank hit is not hit again within 4 cycles. Stride 16 or stride 0 therefore issues one element every 4 cycles.
- R8: A store writes register slot i to the address of element i, in index order. The last write to a repeated address wins.
- R9: `done` is a single-cycle pulse. It follows the last register write of a load, or the last memory write of a store. The unit is idle when `done` is high.
- R10: Negative and zero strides are legal and follow R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request |
| cmd_store | input | 1 | 1 = store register to memory, 0 = load |
| cmd_base | input | 16 | Base word address |
| cmd_stride | input | 16 | Signed word stride |
| cmd_len | input | 8 | Requested element count (clamped to 64) |
| cmd_ready | output | 1 | Unit idle, command accepted when valid |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 64 | Store data |
| mem_rdata | input | 64 | Load data, valid 12 cycles after the request |
| vr_we | output | 1 | Register slot write |
| vr_widx | output | 6 | Register slot written |
| vr_wdata | output | 64 | Register write data |
| vr_ridx | output | 6 | Register slot read for a store |
| vr_rdata | input | 64 | Register read data for `vr_ridx` |

## Verification
The assertions check on every cycle that:
- consecutive issues step the address by the stride;
- two back-to-back issues never land in the same bank;
- the issue count never passes the length;
- register writes happen only while the unit is busy;
- `done` is a one-cycle pulse that coincides with idle;
- a zero-length command completes at once.

Only the bench scenarios can show whole-transfer behaviour. That covers the data values landing in the right slots and addresses, the exact completion cycle counts for streaming and bank-conflict strides, the clamp to 64 elements, that slots past the length are untouched, and that a command offered while busy is dropped.

// File: rtl/vlsu_pkg.sv
package vlsu_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 64;
  localparam int VLEN_MAX  = 64;
  localparam int CMDLEN_W  = 8;
  localparam int N_BANKS   = 16;
  localparam int BANK_BUSY = 4;
  localparam int MEM_LAT   = 12;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_STORE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/vlsu_agen.sv
module vlsu_agen #(
  parameter int AW   = 16,
  parameter int LW   = 7,
  parameter int NB   = 16,
  parameter int BUSY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic [LW-1:0] len_i,
  input  logic          run_i,
  output logic          issue_o,
  output logic          last_o,
  output logic [AW-1:0] addr_o,
  output logic [LW-2:0] idx_o
);
  localparam int BW = $clog2(NB);
  localparam int CW = $clog2(BUSY + 1);
  localparam logic [CW-1:0] RELOAD = CW'(BUSY - 1);

  logic [AW-1:0] addr_q, addr_d, stride_q;
  logic [LW-1:0] cnt_q, cnt_d, len_q;
  logic          step_en, cfg_en;
  logic [BW-1:0] bank_sel;
  logic [NB-1:0] bank_idle;

  // Issue decision: active, elements left, target bank free
  always_comb begin
    bank_sel = addr_q[BW-1:0];
    issue_o  = run_i && (cnt_q != len_q) && bank_idle[bank_sel];
    last_o   = issue_o && (cnt_q == len_q - 1'b1);
    addr_o   = addr_q;
    idx_o    = cnt_q[LW-2:0];
  end

  // Next-state for the element walker
  always_comb begin
    cfg_en  = start_i;
    step_en = start_i || issue_o;
    addr_d  = start_i ? base_i : addr_q + stride_q;
    cnt_d   = start_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      cnt_q    <= '0;
      len_q    <= '0;
      stride_q <= '0;
    end else begin
      if (step_en) begin
        addr_q <= addr_d;
        cnt_q  <= cnt_d;
      end
      if (cfg_en) begin
        len_q    <= len_i;
        stride_q <= stride_i;
      end
    end
  end

  // One occupancy timer per bank
  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [BW-1:0] BID = BW'(b);
    logic [CW-1:0] busy_q, busy_d;
    always_comb begin
      if (issue_o && bank_sel == BID) busy_d = RELOAD;
      else if (busy_q != '0)          busy_d = busy_q - 1'b1;
      else                            busy_d = busy_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= '0;
      else        busy_q <= busy_d;
    end
    assign bank_idle[b] = (busy_q == '0);
  end

  p_stride_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && $past(issue_o)) |-> (addr_o == $past(addr_o) + stride_q))
    else $error("address did not advance by stride");

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= len_q)
    else $error("issue count exceeded length");

  if (BUSY > 1) begin : g_gap_chk
    p_bank_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      issue_o |=> !(issue_o && bank_sel == $past(bank_sel)))
      else $error("bank reissued while occupied");
  end
endmodule

// File: rtl/vlsu_latpipe.sv
module vlsu_latpipe #(
  parameter int DEPTH = 12,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [IW-1:0] in_idx,
  output logic          out_valid,
  output logic          out_last,
  output logic [IW-1:0] out_idx
);
  logic [DEPTH-1:0] v_q;
  logic [DEPTH-1:0] l_q;
  logic [IW-1:0]    i_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic          v_in, l_in, en;
    logic [IW-1:0] i_in;
    if (s == 0) begin : g_head
      always_comb begin
        v_in = in_valid;
        l_in = in_last;
        i_in = in_idx;
      end
    end else begin : g_body
      always_comb begin
        v_in = v_q[s-1];
        l_in = l_q[s-1];
        i_in = i_q[s-1];
      end
    end
    assign en = v_in;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q[s] <= 1'b0;
      else        v_q[s] <= v_in;
    end
    always_ff @(posedge clk) begin
      if (en) begin
        l_q[s] <= l_in;
        i_q[s] <= i_in;
      end
    end
  end

  always_comb begin
    out_valid = v_q[DEPTH-1];
    out_last  = v_q[DEPTH-1] && l_q[DEPTH-1];
    out_idx   = i_q[DEPTH-1];
  end
endmodule

// File: rtl/vlsu_stride.sv
module vlsu_stride
  import vlsu_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int VLEN = VLEN_MAX,
  parameter int CLW  = CMDLEN_W,
  parameter int NB   = N_BANKS,
  parameter int BUSY = BANK_BUSY,
  parameter int LAT  = MEM_LAT,
  localparam int IW  = $clog2(VLEN),
  localparam int LW  = IW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic           cmd_store,
  input  logic [AW-1:0]  cmd_base,
  input  logic [AW-1:0]  cmd_stride,
  input  logic [CLW-1:0] cmd_len,
  output logic           cmd_ready,
  output logic           done,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           vr_we,
  output logic [IW-1:0]  vr_widx,
  output logic [DW-1:0]  vr_wdata,
  output logic [IW-1:0]  vr_ridx,
  input  logic [DW-1:0]  vr_rdata
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  xfer_state_e   state_q, state_d;
  logic          done_q, done_d;
  logic          accept, start, run;
  logic [LW-1:0] len_c;
  logic          iss, iss_last;
  logic [IW-1:0] iss_idx;
  logic          wb_valid, wb_last;
  logic [IW-1:0] wb_idx;

  always_comb begin
    accept = cmd_valid && (state_q == ST_IDLE);
    len_c  = (cmd_len > CLW'(VLEN)) ? LW'(VLEN) : cmd_len[LW-1:0];
    start  = accept && (len_c != '0);
    run    = (state_q == ST_LOAD) || (state_q == ST_STORE);
  end

  vlsu_agen #(.AW(AW), .LW(LW), .NB(NB), .BUSY(BUSY)) u_agen (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .start_i  (start),
    .base_i   (cmd_base),
    .stride_i (cmd_stride),
    .len_i    (len_c),
    .run_i    (run),
    .issue_o  (iss),
    .last_o   (iss_last),
    .addr_o   (mem_addr),
    .idx_o    (iss_idx)
  );

  vlsu_latpipe #(.DEPTH(LAT), .IW(IW)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .in_valid  (iss && (state_q == ST_LOAD)),
    .in_last   (iss_last),
    .in_idx    (iss_idx),
    .out_valid (wb_valid),
    .out_last  (wb_last),
    .out_idx   (wb_idx)
  );

  // Transfer sequencing
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (len_c == '0) done_d  = 1'b1;
        else             state_d = cmd_store ? ST_STORE : ST_LOAD;
      end
      ST_STORE: if (iss_last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      ST_LOAD: if (wb_last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    cmd_ready = (state_q == ST_IDLE);
    done      = done_q;
    mem_req   = iss;
    mem_we    = (state_q == ST_STORE);
    mem_wdata = vr_rdata;
    vr_ridx   = iss_idx;
    vr_we     = wb_valid;
    vr_widx   = wb_idx;
    vr_wdata  = mem_rdata;
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done)
    else $error("done held longer than one cycle");

  p_ready_at_done_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |-> cmd_ready)
    else $error("done while not idle");

  p_wb_busy_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    vr_we |-> !cmd_ready)
    else $error("register write while idle");

  p_len0_done_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_valid && cmd_ready && cmd_len == '0) |=> (done && !mem_req))
    else $error("zero-length command did not complete at once");
endmodule

// File: tb/sim_vlsu_stride.sv
`timescale 1ns/1ps
module sim_vlsu_stride;
  localparam int LAT = 12;
  localparam int MW  = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_store;
  logic [15:0] cmd_base, cmd_stride;
  logic [7:0]  cmd_len;
  logic        cmd_ready, done, mem_req, mem_we, vr_we;
  logic [15:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata, vr_wdata, vr_rdata;
  logic [5:0]  vr_widx, vr_ridx;

  logic [63:0] mem  [MW];
  logic [63:0] vreg [64];
  logic [63:0] src  [64];
  logic [63:0] rpipe [LAT];
  int          req_cnt;
  int          n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  vlsu_stride u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_len(cmd_len),
    .cmd_ready(cmd_ready), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .vr_we(vr_we), .vr_widx(vr_widx), .vr_wdata(vr_wdata),
    .vr_ridx(vr_ridx), .vr_rdata(vr_rdata)
  );

  // Memory model: fixed-latency pipelined read, write on request
  assign mem_rdata = rpipe[LAT-1];
  assign vr_rdata  = src[vr_ridx];
  always @(posedge clk) begin
    rpipe[0] <= mem[mem_addr[9:0]];
    for (int k = 1; k < LAT; k++) rpipe[k] <= rpipe[k-1];
    if (mem_req && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    if (mem_req) req_cnt <= req_cnt + 1;
    if (vr_we) vreg[vr_widx] <= vr_wdata;
  end

  function automatic logic [63:0] pat(int a);
    return {32'(a) * 32'h9E37, 32'(a) ^ 32'h5A5A5A5A};
  endfunction
  function automatic logic [63:0] spat(int i);
    return {32'h51C00000 + 32'(i), 32'(i) * 32'd7};
  endfunction
  function automatic int eaddr(logic [15:0] b, logic [15:0] s, int i);
    logic [15:0] a;
    a = b + 16'(i) * s;
    return int'(a[9:0]);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic init_state();
    for (int a = 0; a < MW; a++) mem[a] = pat(a);
    for (int i = 0; i < 64; i++) begin
      vreg[i] = 64'hEEEE_EEEE_0000_0000 | 64'(i);
      src[i]  = spat(i);
    end
    req_cnt = 0;
  endtask

  // Issues one command; cyc = edges from acceptance to done seen
  task automatic run_cmd(bit st, logic [15:0] b, logic [15:0] s, logic [7:0] n,
                         output int cyc);
    @(posedge clk); #1;
    cmd_store = st; cmd_base = b; cmd_stride = s; cmd_len = n; cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk); #1;
      cyc++;
    end
  endtask

  task automatic check_load(string req, logic [15:0] b, logic [15:0] s, int n);
    int bad = 0, first = -1;
    for (int i = 0; i < 64; i++) begin
      logic [63:0] e;
      e = (i < n) ? pat(eaddr(b, s, i)) : (64'hEEEE_EEEE_0000_0000 | 64'(i));
      if (vreg[i] !== e) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    chk(bad == 0, req, "register slots", bad, 0);
  endtask

  task automatic t_reset();
    chk(cmd_ready === 1'b1, "R1", "ready after reset", cmd_ready, 1);
    chk(done === 1'b0 && mem_req === 1'b0 && vr_we === 1'b0, "R9", "quiet after reset",
        {done, mem_req, vr_we}, 0);
  endtask

  task automatic t_load_unit();
    int c;
    init_state();
    run_cmd(1'b0, 16'd40, 16'd1, 8'd8, c);
    chk(c == 8 + LAT, "R6", "unit-stride load cycles", c, 8 + LAT);
    check_load("R5", 16'd40, 16'd1, 8);
    chk(req_cnt == 8, "R3", "load request count", req_cnt, 8);
  endtask

  task automatic t_load_neg();
    int c;
    init_state();
    run_cmd(1'b0, 16'd300, 16'hFFFD, 8'd20, c);
    check_load("R10", 16'd300, 16'hFFFD, 20);
    chk(c == 20 + LAT, "R2", "negative stride load cycles", c, 20 + LAT);
  endtask

  task automatic t_load_bank();
    int c;
    init_state();
    run_cmd(1'b0, 16'd5, 16'd16, 8'd4, c);
    chk(c == 13 + LAT, "R7", "same-bank load cycles", c, 13 + LAT);
    check_load("R7", 16'd5, 16'd16, 4);
  endtask

  task automatic t_clamp();
    int c;
    init_state();
    run_cmd(1'b0, 16'd100, 16'd1, 8'd70, c);
    chk(c == 64 + LAT, "R3", "clamped load cycles", c, 64 + LAT);
    chk(req_cnt == 64, "R3", "clamped request count", req_cnt, 64);
    check_load("R3", 16'd100, 16'd1, 64);
  endtask

  task automatic t_len0();
    int c;
    init_state();
    run_cmd(1'b0, 16'd0, 16'd1, 8'd0, c);
    chk(c == 0, "R4", "zero-length done cycle", c, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(req_cnt == 0, "R4", "zero-length requests", req_cnt, 0);
    check_load("R4", 16'd0, 16'd1, 0);
  endtask

  task automatic t_store_stride();
    int c, bad = 0;
    init_state();
    run_cmd(1'b1, 16'd600, 16'd3, 8'd10, c);
    @(posedge clk); #1;
    chk(c == 10, "R6", "store cycles", c, 10);
    for (int i = 0; i < 10; i++)
      if (mem[eaddr(16'd600, 16'd3, i)] !== spat(i)) bad++;
    chk(bad == 0, "R8", "strided store data", bad, 0);
    chk(mem[630] === pat(630) && mem[599] === pat(599), "R3", "neighbours untouched",
        mem[630], pat(630));
  endtask

  task automatic t_store_zero();
    int c;
    init_state();
    run_cmd(1'b1, 16'd700, 16'd0, 8'd4, c);
    @(posedge clk); #1;
    chk(c == 13, "R7", "zero-stride store cycles", c, 13);
    chk(mem[700] === spat(3), "R10", "zero-stride last write wins", mem[700], spat(3));
    chk(mem[701] === pat(701), "R8", "zero-stride neighbour", mem[701], pat(701));
  endtask

  task automatic t_busy_ignore();
    int c = 0, bad = 0;
    init_state();
    @(posedge clk); #1;
    cmd_store = 1'b0; cmd_base = 16'd0; cmd_stride = 16'd1; cmd_len = 8'd8; cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    repeat (3) begin @(posedge clk); #1; c++; end
    chk(cmd_ready === 1'b0, "R1", "busy not ready", cmd_ready, 0);
    cmd_store = 1'b1; cmd_base = 16'd500; cmd_len = 8'd8; cmd_valid = 1'b1;
    @(posedge clk); #1; c++;
    cmd_valid = 1'b0;
    while (!done && c < 2000) begin @(posedge clk); #1; c++; end
    chk(c == 8 + LAT, "R1", "timing with ignored command", c, 8 + LAT);
    repeat (3) @(posedge clk);
    #1;
    for (int a = 500; a < 508; a++) if (mem[a] !== pat(a)) bad++;
    chk(bad == 0 && req_cnt == 8, "R1", "ignored store had no effect", req_cnt, 8);
    check_load("R5", 16'd0, 16'd1, 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_store = 1'b0;
    cmd_base = '0; cmd_stride = '0; cmd_len = '0;
    for (int k = 0; k < LAT; k++) rpipe[k] = '0;
    init_state();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_load_unit();
    t_load_neg();
    t_load_bank();
    t_clamp();
    t_len0();
    t_store_stride();
    t_store_zero();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule